// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between the operand fields of a small 8-bit core and its data storage. It forms a 12-bit data address, which splits into a 4-bit bank and an 8-bit offset, for 16 banks of 256 bytes. The address can come from three sources. In banked mode a stored bank register supplies the bank and the instruction supplies the offset. In access mode a fixed window covers the bottom of bank 0 and the control-register area at the top of bank 15. A memory-to-memory move carries full 12-bit source and destination addresses.

Only part of the space holds storage: banks 0 to 2, and the control-register window from the split point of bank 15 up to the top. Writes anywhere else are dropped and reads return zero. The operation still reports completion, so flag logic outside the block behaves as if the access worked.

Operations are offered on a valid/ready pair. The unit never applies back-pressure: `op_ready` is held high, and every cycle with `op_valid` high performs exactly one operation. Reads are combinational. Writes and bank register loads commit on the rising clock edge.

Top module: `banked_mem_unit`

## Requirements
- R1: With `op_kind` 00 (read) or 01 (write) and `op_access` low, the target address is the bank register's 4 bits followed by `op_offset`. It appears on `eff_addr` in the same cycle.
- R2: `op_kind` 11 (load bank) copies bits 3:0 of `op_wdata` into the bank register on the clock edge. `bank_sel` reports the register in bits 3:0 and always reads 0 in bits 7:4.
- R3: Synchronous reset clears the bank register to 0.
- R4: With `op_access` high, an offset below ACC_SPLIT (default 0x60) targets address 0x000 + offset. An offset at or above it targets 0xF00 + offset. The bank register is not used in either case.
- R5: `op_kind` 10 (move) reads the byte at `op_src` onto `rd_data` and writes it to `op_dst` on the clock edge. `eff_addr` shows `op_dst`, and the bank register has no effect.
- R6: Addresses 0x000–0x2FF and 0xF60–0xFFF are implemented. `addr_hit` is high for them, and a byte written there reads back unchanged.
- R7: A write or move to an unimplemented address changes no stored byte, including the byte that shares its low address bits. A read of an unimplemented address returns 0x00, and `addr_hit` is low.
- R8: `op_done` is high in every cycle that has `op_valid` high, whether or not the target is implemented.
- R9: `op_ready` is always high. With `op_valid` low, no byte is stored, the bank register does not change, and `op_done` is low.
- R10: `rd_data` follows the read address in the same cycle. A written value becomes readable only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation offered this cycle |
| op_ready | output | 1 | Always high; the unit never stalls |
| op_kind | input | 2 | 00 read, 01 write, 10 move, 11 load bank |
| op_access | input | 1 | 1 selects access-window mapping, 0 selects banked mapping |
| op_offset | input | 8 | Instruction offset within the bank or the window |
| op_src | input | 12 | Full source address for a move |
| op_dst | input | 12 | Full destination address for a move |
| op_wdata | input | 8 | Write data, or the literal for a bank load |
| rd_data | output | 8 | Byte at the read address; 0 when it is unimplemented |
| eff_addr | output | 12 | Formed target address |
| addr_hit | output | 1 | Target address is implemented |
| op_done | output | 1 | Completion strobe |
| bank_sel | output | 8 | Bank register as read back; upper bits zero |

## Verification
The assertions check several things on every cycle. A bank load lands and the register holds otherwise. Reset clears the register. A move's target is its destination operand. Unimplemented reads yield zero, every offered operation completes, and a committed storage write reads back from the same slot. Other behaviours show up only in the bench's scenarios, which compare against a reference array. These include the access-window split at its exact boundary, the absence of aliasing when a dropped write shares its low bits with a real byte, and moves whose source or destination falls outside the implemented space.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 8;
  localparam int BANK_W = ADDR_W - OFF_W;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_MOVE   = 2'b10,
    OP_LDBANK = 2'b11
  } op_kind_e;
endpackage

// File: rtl/bmu_bank_reg.sv
module bmu_bank_reg #(
  parameter int BANK_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] lit_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [DATA_W-1:0] bank_rd_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst)         bank_q <= '0;
    else if (load_i) bank_q <= lit_i[BANK_W-1:0];
  end

  assign bank_o = bank_q;

  // Only the low bits exist; the rest of the readback is tied low.
  generate
    if (DATA_W > BANK_W) begin : g_pad
      assign bank_rd_o = {{(DATA_W-BANK_W){1'b0}}, bank_q};
    end else begin : g_full
      assign bank_rd_o = bank_q[DATA_W-1:0];
    end
  endgenerate

  p_bank_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> bank_q == $past(lit_i[BANK_W-1:0]));
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(bank_q));
  p_bank_clear_r3: assert property (@(posedge clk)
    rst |=> bank_q == '0);
endmodule

// File: rtl/bmu_addr_gen.sv
module bmu_addr_gen #(
  parameter int              ADDR_W    = 12,
  parameter int              OFF_W     = 8,
  parameter logic [OFF_W-1:0] ACC_SPLIT = 8'h60,
  localparam int             BANK_W    = ADDR_W - OFF_W
) (
  input  logic              is_move_i,
  input  logic              access_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  logic [ADDR_W-1:0] banked_addr;
  logic [ADDR_W-1:0] window_addr;
  logic [ADDR_W-1:0] formed;

  always_comb begin
    banked_addr = {bank_i, offset_i};
    if (offset_i < ACC_SPLIT) window_addr = {{BANK_W{1'b0}}, offset_i};
    else                      window_addr = {{BANK_W{1'b1}}, offset_i};
    formed    = access_i ? window_addr : banked_addr;
    rd_addr_o = is_move_i ? src_i : formed;
    wr_addr_o = is_move_i ? dst_i : formed;
  end
endmodule

// File: rtl/bmu_map_decode.sv
module bmu_map_decode #(
  parameter int                ADDR_W    = 12,
  parameter int                GPR_DEPTH = 768,
  parameter logic [ADDR_W-1:0] SFR_BASE  = 12'hF60,
  parameter int                GIDX_W    = 10,
  parameter int                SIDX_W    = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              gpr_o,
  output logic              sfr_o,
  output logic [GIDX_W-1:0] gidx_o,
  output logic [SIDX_W-1:0] sidx_o
);
  always_comb begin
    gpr_o  = (int'(addr_i) < GPR_DEPTH);
    sfr_o  = (addr_i >= SFR_BASE);
    gidx_o = addr_i[GIDX_W-1:0];
    sidx_o = SIDX_W'(addr_i - SFR_BASE);
  end
endmodule

// File: rtl/bmu_store.sv
module bmu_store #(
  parameter int DATA_W    = 8,
  parameter int GPR_DEPTH = 768,
  parameter int SFR_DEPTH = 160,
  parameter int GIDX_W    = 10,
  parameter int SIDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_gpr_i,
  input  logic              rd_sfr_i,
  input  logic [GIDX_W-1:0] rd_gidx_i,
  input  logic [SIDX_W-1:0] rd_sidx_i,
  input  logic              wr_en_i,
  input  logic              wr_gpr_i,
  input  logic              wr_sfr_i,
  input  logic [GIDX_W-1:0] wr_gidx_i,
  input  logic [SIDX_W-1:0] wr_sidx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] gpr_mem [GPR_DEPTH];
  logic [DATA_W-1:0] sfr_rd;

  always_ff @(posedge clk) begin
    if (wr_en_i && wr_gpr_i) gpr_mem[wr_gidx_i] <= wdata_i;
  end

  generate
    if (SFR_DEPTH > 0) begin : g_sfr
      logic [DATA_W-1:0] sfr_mem [SFR_DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en_i && wr_sfr_i) sfr_mem[wr_sidx_i] <= wdata_i;
      end
      assign sfr_rd = sfr_mem[rd_sidx_i];

      p_sfr_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sfr_i) |=> sfr_mem[$past(wr_sidx_i)] == $past(wdata_i));
    end else begin : g_nosfr
      assign sfr_rd = '0;
    end
  endgenerate

  always_comb begin
    if (rd_gpr_i)      rdata_o = gpr_mem[rd_gidx_i];
    else if (rd_sfr_i) rdata_o = sfr_rd;
    else               rdata_o = '0;
  end

  p_gpr_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_gpr_i) |=> gpr_mem[$past(wr_gidx_i)] == $past(wdata_i));
  p_one_region_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_gpr_i && wr_sfr_i));
endmodule

// File: rtl/banked_mem_unit.sv
module banked_mem_unit
  import bmu_pkg::*;
#(
  parameter int                IMPL_BANKS = 3,
  parameter logic [OFF_W-1:0]  ACC_SPLIT  = 8'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic              op_access,
  input  logic [OFF_W-1:0]  op_offset,
  input  logic [ADDR_W-1:0] op_src,
  input  logic [ADDR_W-1:0] op_dst,
  input  logic [DATA_W-1:0] op_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              addr_hit,
  output logic              op_done,
  output logic [DATA_W-1:0] bank_sel
);
  localparam int                GPR_DEPTH = IMPL_BANKS * (2 ** OFF_W);
  localparam logic [ADDR_W-1:0] SFR_BASE  = {{BANK_W{1'b1}}, ACC_SPLIT};
  localparam int                SFR_DEPTH = (2 ** ADDR_W) - int'(SFR_BASE);
  localparam int                GIDX_W    = $clog2(GPR_DEPTH);
  localparam int                SIDX_W    = (SFR_DEPTH > 1) ? $clog2(SFR_DEPTH) : 1;

  op_kind_e          kind;
  logic              take;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              rd_gpr, rd_sfr, wr_gpr, wr_sfr;
  logic [GIDX_W-1:0] rd_gidx, wr_gidx;
  logic [SIDX_W-1:0] rd_sidx, wr_sidx;
  logic              wr_en;
  logic [DATA_W-1:0] store_wdata;

  assign kind     = op_kind_e'(op_kind);
  assign op_ready = 1'b1;
  assign take     = op_valid && op_ready;

  bmu_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load_i   (take && kind == OP_LDBANK),
    .lit_i    (op_wdata),
    .bank_o   (bank),
    .bank_rd_o(bank_sel)
  );

  bmu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ACC_SPLIT(ACC_SPLIT)) u_agen (
    .is_move_i(kind == OP_MOVE),
    .access_i (op_access),
    .bank_i   (bank),
    .offset_i (op_offset),
    .src_i    (op_src),
    .dst_i    (op_dst),
    .rd_addr_o(rd_addr),
    .wr_addr_o(wr_addr)
  );

  bmu_map_decode #(.ADDR_W(ADDR_W), .GPR_DEPTH(GPR_DEPTH), .SFR_BASE(SFR_BASE),
                   .GIDX_W(GIDX_W), .SIDX_W(SIDX_W)) u_rd_map (
    .addr_i(rd_addr), .gpr_o(rd_gpr), .sfr_o(rd_sfr),
    .gidx_o(rd_gidx), .sidx_o(rd_sidx)
  );

  bmu_map_decode #(.ADDR_W(ADDR_W), .GPR_DEPTH(GPR_DEPTH), .SFR_BASE(SFR_BASE),
                   .GIDX_W(GIDX_W), .SIDX_W(SIDX_W)) u_wr_map (
    .addr_i(wr_addr), .gpr_o(wr_gpr), .sfr_o(wr_sfr),
    .gidx_o(wr_gidx), .sidx_o(wr_sidx)
  );

  assign store_wdata = (kind == OP_MOVE) ? rd_data : op_wdata;
  assign wr_en       = take && (kind == OP_WRITE || kind == OP_MOVE);

  bmu_store #(.DATA_W(DATA_W), .GPR_DEPTH(GPR_DEPTH), .SFR_DEPTH(SFR_DEPTH),
              .GIDX_W(GIDX_W), .SIDX_W(SIDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_gpr_i (rd_gpr),
    .rd_sfr_i (rd_sfr),
    .rd_gidx_i(rd_gidx),
    .rd_sidx_i(rd_sidx),
    .wr_en_i  (wr_en),
    .wr_gpr_i (wr_gpr),
    .wr_sfr_i (wr_sfr),
    .wr_gidx_i(wr_gidx),
    .wr_sidx_i(wr_sidx),
    .wdata_i  (store_wdata),
    .rdata_o  (rd_data)
  );

  assign eff_addr = wr_addr;
  assign addr_hit = wr_gpr || wr_sfr;
  assign op_done  = take;

  p_move_target_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && kind == OP_MOVE) |-> eff_addr == op_dst);
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && kind != OP_MOVE && kind != OP_LDBANK && !addr_hit) |-> rd_data == '0);
  p_done_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !addr_hit) |-> op_done);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> !op_done);
  p_upper_bank_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bank_sel[DATA_W-1:BANK_W] == '0);
endmodule

// File: tb/test_banked_mem_unit.sv
`timescale 1ns/1ps
module test_banked_mem_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_kind;
  logic        op_access;
  logic [7:0]  op_offset;
  logic [11:0] op_src, op_dst;
  logic [7:0]  op_wdata;
  logic [7:0]  rd_data;
  logic [11:0] eff_addr;
  logic        addr_hit;
  logic        op_done;
  logic [7:0]  bank_sel;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] ref_mem [4096];
  logic [3:0] bank_m;

  always #5 clk = ~clk;

  banked_mem_unit i_banked_mem_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_access(op_access), .op_offset(op_offset),
    .op_src(op_src), .op_dst(op_dst), .op_wdata(op_wdata),
    .rd_data(rd_data), .eff_addr(eff_addr), .addr_hit(addr_hit),
    .op_done(op_done), .bank_sel(bank_sel)
  );

  function automatic logic mapped(input logic [11:0] a);
    return (a < 12'h300) || (a >= 12'hF60);
  endfunction

  function automatic logic [11:0] target(input logic acc, input logic [7:0] off);
    if (!acc)           return {bank_m, off};
    else if (off < 8'h60) return {4'h0, off};
    else                return {4'hF, off};
  endfunction

  function automatic logic [7:0] expect_rd(input logic [11:0] a);
    return mapped(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [1:0] k, input logic acc,
                     input logic [7:0] off, input logic [11:0] s, input logic [11:0] d,
                     input logic [7:0] wd);
    @(negedge clk);
    op_valid = v; op_kind = k; op_access = acc; op_offset = off;
    op_src = s; op_dst = d; op_wdata = wd;
    #1;
  endtask

  task automatic settle;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic load_bank(input logic [7:0] lit);
    put(1'b1, 2'b11, 1'b0, 8'h00, 12'h0, 12'h0, lit);
    settle();
    bank_m = lit[3:0];
    check("R2 bank low bits", {24'h0, bank_sel}, {28'h0, lit[3:0]});
  endtask

  task automatic do_write(input string req, input logic acc, input logic [7:0] off,
                          input logic [7:0] wd);
    logic [11:0] a;
    a = target(acc, off);
    put(1'b1, 2'b01, acc, off, 12'h0, 12'h0, wd);
    check({req, " write addr"}, {20'h0, eff_addr}, {20'h0, a});
    check({req, " write hit"}, {31'h0, addr_hit}, {31'h0, mapped(a)});
    check("R8 done on write", {31'h0, op_done}, 32'h1);
    settle();
    if (mapped(a)) ref_mem[a] = wd;
  endtask

  task automatic do_read(input string req, input logic acc, input logic [7:0] off);
    logic [11:0] a;
    a = target(acc, off);
    put(1'b1, 2'b00, acc, off, 12'h0, 12'h0, 8'h00);
    check({req, " read addr"}, {20'h0, eff_addr}, {20'h0, a});
    check({req, " read data"}, {24'h0, rd_data}, {24'h0, expect_rd(a)});
    check("R8 done on read", {31'h0, op_done}, 32'h1);
    settle();
  endtask

  task automatic t_reset;
    rst = 1'b1;
    op_valid = 1'b0; op_kind = 2'b00; op_access = 1'b0; op_offset = 8'h0;
    op_src = 12'h0; op_dst = 12'h0; op_wdata = 8'h0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    bank_m = 4'h0;
    check("R3 bank after reset", {24'h0, bank_sel}, 32'h0);
    check("R9 ready high", {31'h0, op_ready}, 32'h1);
    check("R9 done idle", {31'h0, op_done}, 32'h0);
  endtask

  task automatic t_bank_load;
    load_bank(8'hA7);
    load_bank(8'hF2);
    load_bank(8'h09);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    bank_m = 4'h0;
    check("R3 bank after mid reset", {24'h0, bank_sel}, 32'h0);
  endtask

  task automatic t_banked;
    load_bank(8'h01);
    do_write("R1", 1'b0, 8'h34, 8'h5A);
    do_write("R1", 1'b0, 8'h10, 8'h77);
    load_bank(8'h02);
    do_write("R6", 1'b0, 8'hFF, 8'hC3);
    load_bank(8'h00);
    do_write("R6", 1'b0, 8'h00, 8'h11);
    load_bank(8'h01);
    do_read("R1", 1'b0, 8'h34);
    do_read("R1", 1'b0, 8'h10);
    load_bank(8'h02);
    do_read("R6", 1'b0, 8'hFF);
  endtask

  task automatic t_access;
    load_bank(8'h07);
    do_write("R4 below split", 1'b1, 8'h5F, 8'h24);
    do_write("R4 at split", 1'b1, 8'h60, 8'h81);
    do_write("R4 top", 1'b1, 8'hFF, 8'h9E);
    load_bank(8'h00);
    do_read("R4 via bank0", 1'b0, 8'h5F);
    load_bank(8'h0F);
    do_read("R4 via bank15", 1'b0, 8'h60);
    do_read("R6 sfr top", 1'b0, 8'hFF);
    do_read("R7 below sfr window", 1'b0, 8'h5F);
  endtask

  task automatic t_unmapped;
    load_bank(8'h05);
    do_write("R7", 1'b0, 8'h10, 8'h55);
    do_read("R7", 1'b0, 8'h10);
    load_bank(8'h03);
    do_write("R7 boundary", 1'b0, 8'h00, 8'hAB);
    do_read("R7 boundary", 1'b0, 8'h00);
    load_bank(8'h01);
    do_read("R7 no alias", 1'b0, 8'h10);
    load_bank(8'h0F);
    do_write("R7 sfr gap", 1'b0, 8'h20, 8'hEE);
    do_read("R7 sfr gap", 1'b0, 8'h20);
  endtask

  task automatic t_move;
    load_bank(8'h03);
    put(1'b1, 2'b10, 1'b0, 8'h99, 12'h134, 12'h2AA, 8'h00);
    check("R5 move dst addr", {20'h0, eff_addr}, 32'h2AA);
    check("R5 move src data", {24'h0, rd_data}, {24'h0, ref_mem[12'h134]});
    check("R8 done on move", {31'h0, op_done}, 32'h1);
    settle();
    ref_mem[12'h2AA] = ref_mem[12'h134];
    load_bank(8'h02);
    do_read("R5 move landed", 1'b0, 8'hAA);
    put(1'b1, 2'b10, 1'b0, 8'h00, 12'h700, 12'hF80, 8'h00);
    check("R5 move unmapped src", {24'h0, rd_data}, 32'h0);
    settle();
    ref_mem[12'hF80] = 8'h00;
    load_bank(8'h0F);
    do_read("R5 zero moved", 1'b0, 8'h80);
    put(1'b1, 2'b10, 1'b0, 8'h00, 12'h2AA, 12'h800, 8'h00);
    check("R7 move dst miss", {31'h0, addr_hit}, 32'h0);
    check("R8 done miss", {31'h0, op_done}, 32'h1);
    settle();
    load_bank(8'h00);
    do_read("R7 move no alias", 1'b0, 8'h00);
  endtask

  task automatic t_idle_and_timing;
    load_bank(8'h01);
    put(1'b0, 2'b01, 1'b0, 8'h10, 12'h0, 12'h0, 8'hEE);
    check("R9 done low when idle", {31'h0, op_done}, 32'h0);
    settle();
    put(1'b0, 2'b11, 1'b0, 8'h00, 12'h0, 12'h0, 8'h0C);
    settle();
    check("R9 bank unchanged", {24'h0, bank_sel}, 32'h1);
    do_read("R9 byte unchanged", 1'b0, 8'h10);
    put(1'b1, 2'b01, 1'b0, 8'h10, 12'h0, 12'h0, 8'h3D);
    check("R10 old value before edge", {24'h0, rd_data}, {24'h0, ref_mem[12'h110]});
    settle();
    ref_mem[12'h110] = 8'h3D;
    do_read("R10 new value after edge", 1'b0, 8'h10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) ref_mem[i] = 8'h00;
    t_reset();
    t_bank_load();
    t_banked();
    t_access();
    t_unmapped();
    t_move();
    t_idle_and_timing();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule